// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is the arithmetic and logic stage of a small load/store integer datapath. It takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag. The datapath is a chain of identical one-bit cells. Each cell forms the AND, the OR and the full-adder sum of its operand bits at the same time, and a small per-bit selector picks one of them. The top bit of the operation code inverts the B operand and also supplies the first carry-in. Subtraction therefore runs on the same adder chain as addition.

A set-on-less-than operation takes the sign of A minus B, as produced by the most significant cell. That value is returned on bit 0 of the result, and every other result bit is zero. The computed values are captured in output registers, so a result appears one clock after its operands. A synchronous active-high reset clears those registers.

Top module: `bs_alu`

## Requirements
- R1: Code 000 returns the bitwise AND of A and B.
- R2: Code 001 returns the bitwise OR of A and B.
- R3: Code 010 returns A plus B modulo 2^32. The overflow flag is high exactly when A and B have the same sign and the sum has the other sign.
- R4: Code 110 returns A minus B modulo 2^32, computed as A plus inverted B plus one. The overflow flag is high exactly when A and B differ in sign and the difference has a sign different from A.
- R5: Code 111 returns 1 in bit 0 when bit 31 of the 32-bit difference A minus B is set, and 0 otherwise. Bits 31..1 are zero. No correction is made for overflow of that difference.
- R6: The zero flag is high exactly when all 32 bits of the registered result are zero.
- R7: The overflow flag is low for every code other than 010 and 110.
- R8: Codes 011, 100 and 101 return a result of all zeros. For these codes the zero flag is high and the overflow flag is low.
- R9: Result and flags are registered. Operands and code presented before a rising edge are reflected after that edge. While reset is high at an edge, the result becomes 0, the zero flag becomes 1 and the overflow flag becomes 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Registered all-zero indication of the result |
| ovf_flag | output | 1 | Registered signed overflow for add and subtract |

## Verification
Two flags are produced in the same cycle as a subtraction or an addition: the zero flag and the overflow flag. Both come from the same ripple of carries that forms the result. Equal operands under subtraction drive the zero flag while overflow must stay low. Operand pairs such as 0x80000000 minus 1, or 0x7FFFFFFF plus 1, set overflow while the result is non-zero. Set-on-less-than is applied to those same overflowing pairs, so the reported bit is judged against the raw sign of the wrapped difference. Every item is compared against a reference computed in the bench, one cycle after it is driven.

// File: rtl/bs_alu_pkg.sv
package bs_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // per-cell selector values, driven by the low two code bits
  localparam logic [1:0] PICK_AND  = 2'b00;
  localparam logic [1:0] PICK_OR   = 2'b01;
  localparam logic [1:0] PICK_SUM  = 2'b10;
  localparam logic [1:0] PICK_LESS = 2'b11;

  function automatic logic op_defined(input logic [2:0] code);
    return (code == OP_AND) || (code == OP_OR) || (code == OP_ADD) ||
           (code == OP_SUB) || (code == OP_SLT);
  endfunction

  function automatic logic op_arith(input logic [2:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/bs_alu_cell.sv
// One ordinary bit position of the ALU chain.
module bs_alu_cell
  import bs_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic       b_invert,
  input  logic [1:0] pick,
  output logic       res_bit,
  output logic       carry_out
);

  logic b_eff;
  logic sum_bit;

  assign b_eff     = b_bit ^ b_invert;
  assign sum_bit   = a_bit ^ b_eff ^ carry_in;
  assign carry_out = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);

  always_comb begin
    unique case (pick)
      PICK_AND: res_bit = a_bit & b_eff;
      PICK_OR:  res_bit = a_bit | b_eff;
      PICK_SUM: res_bit = sum_bit;
      default:  res_bit = less_in;
    endcase
  end

endmodule

// File: rtl/bs_alu_msb_cell.sv
// Top bit position: additionally exports the raw sum (sign) and overflow.
module bs_alu_msb_cell
  import bs_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic       b_invert,
  input  logic [1:0] pick,
  output logic       res_bit,
  output logic       sign_out,
  output logic       ovf_out
);

  logic b_eff;
  logic carry_out;

  assign b_eff     = b_bit ^ b_invert;
  assign sign_out  = a_bit ^ b_eff ^ carry_in;
  assign carry_out = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
  assign ovf_out   = carry_in ^ carry_out;

  always_comb begin
    unique case (pick)
      PICK_AND: res_bit = a_bit & b_eff;
      PICK_OR:  res_bit = a_bit | b_eff;
      PICK_SUM: res_bit = sign_out;
      default:  res_bit = less_in;
    endcase
  end

endmodule

// File: rtl/bs_alu_chain.sv
// Combinational chain of WIDTH cells plus code gating and zero detect.
module bs_alu_chain
  import bs_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       code,
  output logic [WIDTH-1:0] res_out,
  output logic             zero_out,
  output logic             ovf_out
);

  localparam int MSB = WIDTH - 1;

  logic             b_invert;
  logic [1:0]       pick;
  logic [WIDTH-1:0] raw_res;
  logic             sign_bit;
  logic             raw_ovf;

  assign b_invert = code[2];
  assign pick     = code[1:0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic c_in;
    logic c_out;
    logic l_in;

    if (i == 0) begin : g_first
      assign c_in = b_invert;
      assign l_in = sign_bit;
    end else begin : g_rest
      assign c_in = g_bit[i-1].c_out;
      assign l_in = 1'b0;
    end

    if (i == MSB) begin : g_msb
      bs_alu_msb_cell u_cell (
        .a_bit    (a_in[i]),
        .b_bit    (b_in[i]),
        .carry_in (c_in),
        .less_in  (l_in),
        .b_invert (b_invert),
        .pick     (pick),
        .res_bit  (raw_res[i]),
        .sign_out (sign_bit),
        .ovf_out  (raw_ovf)
      );
      assign c_out = 1'b0;
    end else begin : g_mid
      bs_alu_cell u_cell (
        .a_bit     (a_in[i]),
        .b_bit     (b_in[i]),
        .carry_in  (c_in),
        .less_in   (l_in),
        .b_invert  (b_invert),
        .pick      (pick),
        .res_bit   (raw_res[i]),
        .carry_out (c_out)
      );
    end
  end

  assign res_out  = op_defined(code) ? raw_res : '0;
  assign ovf_out  = op_arith(code) & raw_ovf;
  assign zero_out = ~|res_out;

endmodule

// File: rtl/bs_alu.sv
module bs_alu
  import bs_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag
);

  logic [WIDTH-1:0] nxt_res;
  logic             nxt_zero;
  logic             nxt_ovf;

  bs_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_in     (op_a),
    .b_in     (op_b),
    .code     (op_sel),
    .res_out  (nxt_res),
    .zero_out (nxt_zero),
    .ovf_out  (nxt_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      zero_flag <= 1'b1;
      ovf_flag  <= 1'b0;
    end else begin
      result    <= nxt_res;
      zero_flag <= nxt_zero;
      ovf_flag  <= nxt_ovf;
    end
  end

endmodule

// File: rtl/bs_alu_chk.sv
module bs_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             ovf_flag
);

  p_and_r1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000) |=> (result == ($past(op_a) & $past(op_b))));

  p_or_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b001) |=> (result == ($past(op_a) | $past(op_b))));

  p_add_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b010) |=> (result == ($past(op_a) + $past(op_b))));

  p_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b110) |=> (result == ($past(op_a) - $past(op_b))));

  p_slt_high_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b111) |=> (result[WIDTH-1:1] == '0));

  p_zero_match_r6: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (result == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    !((op_sel == 3'b010) || (op_sel == 3'b110)) |=> !ovf_flag);

  p_unused_r8: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == 3'b011) || (op_sel == 3'b100) || (op_sel == 3'b101))
      |=> (result == '0 && zero_flag && !ovf_flag));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (result == '0 && zero_flag && !ovf_flag));

endmodule

bind bs_alu bs_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sel    (op_sel),
  .result    (result),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/bs_alu_test.sv
module bs_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        z;
    logic        v;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  op_sel = '0;
  logic [31:0] result;
  logic        zero_flag;
  logic        ovf_flag;

  int n_vec  = 0;
  int n_miss = 0;
  item_t q[$];

  bs_alu #(.WIDTH(32)) uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic item_t model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] op);
    item_t it;
    logic [31:0] s, d;
    s = a + b;
    d = a - b;
    it.a = a; it.b = b; it.op = op; it.v = 1'b0;
    case (op)
      3'b000: it.res = a & b;                                   // R1
      3'b001: it.res = a | b;                                   // R2
      3'b010: begin                                             // R3
        it.res = s;
        it.v   = (a[31] == b[31]) && (s[31] != a[31]);
      end
      3'b110: begin                                             // R4
        it.res = d;
        it.v   = (a[31] != b[31]) && (d[31] != a[31]);
      end
      3'b111: it.res = {31'b0, d[31]};                          // R5
      default: it.res = '0;                                     // R8, R7
    endcase
    it.z = (it.res == '0);                                      // R6
    return it;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op;
    q.push_back(model(a, b, op));
  endtask

  // monitor: results appear one edge after the item was driven (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_vec++;
        if (result !== e.res || zero_flag !== e.z || ovf_flag !== e.v) begin
          n_miss++;
          $display("FAIL %s/R6/R7/R9 op=%b a=%h b=%h actual res=%h z=%b v=%b expected res=%h z=%b v=%b",
                   tag_of(e.op), e.op, e.a, e.b, result, zero_flag, ovf_flag,
                   e.res, e.z, e.v);
        end
      end
    end
  end

  task automatic check_reset_state(input string when);
    n_vec++;
    if (result !== 32'h0 || zero_flag !== 1'b1 || ovf_flag !== 1'b0) begin
      n_miss++;
      $display("FAIL R9 reset (%s) actual res=%h z=%b v=%b expected res=00000000 z=1 v=0",
               when, result, zero_flag, ovf_flag);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog R9 actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    logic [31:0] corners [8];
    logic [2:0]  codes   [8];
    corners = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                32'h1, 32'h8000_0001, 32'h5555_AAAA, 32'h7FFF_FFFE};
    codes   = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};

    // R9: reset dominates live inputs
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; op_sel = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("power-up");
    rst = 1'b0;

    // every code over corner pairs, including equal operands
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(corners[i], corners[j], codes[c]);

    // targeted zero / overflow collisions (R3 R4 R5 R6)
    drive(32'h7FFF_FFFF, 32'h1,         3'b010);
    drive(32'h8000_0000, 32'h1,         3'b110);
    drive(32'h8000_0000, 32'h1,         3'b111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);
    drive(32'hFFFF_FFFF, 32'h1,         3'b010);
    drive(32'h8000_0000, 32'h8000_0000, 3'b010);

    // random operands across all codes
    for (int k = 0; k < 1200; k++)
      drive($urandom, $urandom, 3'($urandom));

    // drain, then reset after live data (R9)
    @(negedge clk);
    op_sel = 3'b001; op_a = 32'hF0F0_F0F0; op_b = 32'h1;
    wait (q.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("mid-run");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule